// File: doc/BRIEF.md
# Tagged geometric-history branch direction predictor

This block guesses whether a conditional branch will be taken. A table of two-bit counters indexed by the branch address gives a fallback guess. Several tagged tables refine that guess, each selected by a hash of the address, a different amount of global outcome history and a short history of address bits. History lengths double from one tagged table to the next. The longest-history table whose stored tag matches supplies the prediction.

The lookup port is purely combinational. Given an address, it returns in the same cycle the direction, the alternate direction, the providing table and every index and tag it computed. The caller keeps these values. When the branch resolves, the caller returns them on the update port together with the real outcome, in program order and at most one per cycle. The update trains the providing counter and adjusts its usefulness. After a wrong guess it claims an entry in a longer-history table. It then shifts both histories.

Top module: `tage_predictor`

## Requirements
- R1: After reset both histories are zero, every fallback counter holds 1 (weak not-taken) and every tagged entry is invalid. The first lookup therefore returns not-taken from provider 0.
- R2: The fallback index is address bits [9:2]. The fallback guess is taken when its counter is 2 or 3.
- R3: For tagged table t (1..4) with history length L = 4·2^(t-1), the index is pc[7:2] ^ pc[13:8] ^ F6(ghist, L) ^ F6(path, min(L,16)). Here Fw(x, n) has bit k equal to the XOR of every x[i] with i < n and i mod w = k. The index of table t sits at pred_idx[6(t-1) +: 6].
- R4: The tag of table t is pc[17:10] ^ F8(ghist, L) ^ (F7(ghist, L) << 1), truncated to 8 bits. It sits at pred_tag[8(t-1) +: 8].
- R5: The provider code is the highest-numbered tagged table whose entry at its index is valid with an equal tag, or 0 when none hits. A tagged provider predicts taken when its 3-bit two's-complement counter is >= 0.
- R6: The alternate guess comes from the next lower hitting table, or from the fallback counter when there is none. With provider 0 the alternate equals the prediction.
- R7: An update moves the provider's counter one step toward the outcome, saturating at -4..3 for tagged counters and 0..3 for fallback counters. The provider's counter is the fallback counter when the provider is 0.
- R8: The provider's 2-bit useful counter rises (saturating at 3) when its guess was right and the alternate differed. It falls (saturating at 0) when its guess was wrong and the alternate was right.
- R9: On a wrong guess, the lowest-numbered table above the provider whose entry at its update index has a useful count of 0 receives a new entry. That entry is valid, carries the update tag, has a useful count of 0 and has a counter of 0 for a taken outcome or -1 for not-taken.
- R10: On a wrong guess with no such entry, every table above the provider decrements its useful counter at the update index. A wrong guess from table 4 allocates nothing.
- R11: Each valid update shifts the outcome into bit 0 of the 32-bit global history and shifts address bit 2 into bit 0 of the 16-bit path history. Without an update, neither history changes.
- R12: An update changes the next cycle's lookup results. A lookup in the same cycle still sees the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| pred_pc | input | 32 | address to look up |
| pred_taken | output | 1 | predicted direction |
| pred_alt_taken | output | 1 | alternate direction |
| pred_provider | output | 3 | providing table, 0 = fallback |
| pred_bidx | output | 8 | fallback index |
| pred_idx | output | 24 | tagged indices, 6 bits per table |
| pred_tag | output | 32 | tagged tags, 8 bits per table |
| upd_valid | input | 1 | update strobe |
| upd_pc | input | 32 | address of the resolved branch |
| upd_taken | input | 1 | resolved outcome |
| upd_pred_taken | input | 1 | saved pred_taken |
| upd_alt_taken | input | 1 | saved pred_alt_taken |
| upd_provider | input | 3 | saved pred_provider |
| upd_bidx | input | 8 | saved pred_bidx |
| upd_idx | input | 24 | saved pred_idx |
| upd_tag | input | 32 | saved pred_tag |

## Verification
The properties assume that update fields are echoes of a lookup made against the same state, in program order, and that the provider code never exceeds the table count. The stimulus enforces this by looking up and updating each branch in one cycle. It sends the lookup outputs back unchanged and inserts idle cycles only between whole branches. This means the indices, tags and provider on the update port always match the state present when the update lands.

// File: rtl/tage_pkg.sv
package tage_pkg;

    localparam int TAG_W = 8;
    localparam int CTR_W = 3;
    localparam int U_W   = 2;

    typedef struct packed {
        logic                    vld;
        logic [TAG_W-1:0]        tag;
        logic signed [CTR_W-1:0] ctr;
        logic [U_W-1:0]          usef;
    } tent_t;

    // XOR-fold the low len bits of src onto w bit lanes
    function automatic logic [31:0] fold_bits(input logic [63:0] src,
                                              input int unsigned len,
                                              input int unsigned w);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < len) begin
                r[i % w] = r[i % w] ^ src[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tage_hash.sv
module tage_hash #(
    parameter int PC_W      = 32,
    parameter int HIST_W    = 32,
    parameter int PATH_W    = 16,
    parameter int HLEN      = 4,
    parameter int TIDX_W    = 6,
    parameter int TAG_PC_LO = 10
) (
    input  logic [PC_W-1:0]           pc,
    input  logic [HIST_W-1:0]         ghist,
    input  logic [PATH_W-1:0]         path,
    output logic [TIDX_W-1:0]         idx,
    output logic [tage_pkg::TAG_W-1:0] tag
);
    import tage_pkg::*;

    localparam int PLEN = (HLEN < PATH_W) ? HLEN : PATH_W;

    logic [TIDX_W-1:0] g_idx, p_idx;
    logic [TAG_W-1:0]  g_tag, g_tag7;
    logic              unused_pc;

    assign unused_pc = ^pc;

    always_comb begin
        g_idx  = TIDX_W'(fold_bits(64'(ghist), HLEN, TIDX_W));
        p_idx  = TIDX_W'(fold_bits(64'(path), PLEN, TIDX_W));
        g_tag  = TAG_W'(fold_bits(64'(ghist), HLEN, TAG_W));
        g_tag7 = TAG_W'(fold_bits(64'(ghist), HLEN, TAG_W - 1));
        idx = pc[2 +: TIDX_W] ^ pc[2 + TIDX_W +: TIDX_W] ^ g_idx ^ p_idx;
        tag = pc[TAG_PC_LO +: TAG_W] ^ g_tag ^ (g_tag7 << 1);
    end

endmodule

// File: rtl/tage_bank.sv
module tage_bank #(
    parameter int TIDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIDX_W-1:0]    rd_idx,
    output tage_pkg::tent_t      rd_ent,
    input  logic [TIDX_W-1:0]    up_idx,
    output tage_pkg::tent_t      up_ent,
    input  logic                 wr_en,
    input  tage_pkg::tent_t      wr_ent
);
    import tage_pkg::*;

    localparam int DEPTH = 1 << TIDX_W;

    typedef struct packed {
        tent_t [DEPTH-1:0] mem;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[up_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ent = st_q.mem[rd_idx];
    assign up_ent = st_q.mem[up_idx];

endmodule

// File: rtl/tage_bimodal.sv
module tage_bimodal #(
    parameter int BIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BIDX_W-1:0] rd_idx,
    output logic [1:0]        rd_ctr,
    input  logic [BIDX_W-1:0] up_idx,
    output logic [1:0]        up_ctr,
    input  logic              wr_en,
    input  logic [1:0]        wr_ctr
);
    localparam int DEPTH = 1 << BIDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } bim_t;

    bim_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[up_idx] = wr_ctr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{2'b01}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.ctr[rd_idx];
    assign up_ctr = st_q.ctr[up_idx];

endmodule

// File: rtl/tage_select.sv
module tage_select #(
    parameter int NTAB   = 4,
    parameter int PROV_W = 3
) (
    input  logic [NTAB-1:0]   hit,
    input  logic [NTAB-1:0]   dir,
    input  logic              base_dir,
    output logic [PROV_W-1:0] provider,
    output logic              taken,
    output logic              alt_taken
);
    always_comb begin
        provider  = '0;
        taken     = base_dir;
        alt_taken = base_dir;
        for (int t = 0; t < NTAB; t++) begin
            if (hit[t]) begin
                alt_taken = taken;
                taken     = dir[t];
                provider  = PROV_W'(t + 1);
            end
        end
    end

endmodule

// File: rtl/tage_predictor.sv
module tage_predictor #(
    parameter int PC_W      = 32,
    parameter int NTAB      = 4,
    parameter int BASE_HIST = 4,
    parameter int TIDX_W    = 6,
    parameter int BIDX_W    = 8,
    parameter int PATH_W    = 16,
    parameter int PATH_BIT  = 2,
    localparam int PROV_W   = $clog2(NTAB + 1),
    localparam int TAGS_W   = NTAB * tage_pkg::TAG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PC_W-1:0]        pred_pc,
    output logic                   pred_taken,
    output logic                   pred_alt_taken,
    output logic [PROV_W-1:0]      pred_provider,
    output logic [BIDX_W-1:0]      pred_bidx,
    output logic [NTAB*TIDX_W-1:0] pred_idx,
    output logic [TAGS_W-1:0]      pred_tag,
    input  logic                   upd_valid,
    input  logic [PC_W-1:0]        upd_pc,
    input  logic                   upd_taken,
    input  logic                   upd_pred_taken,
    input  logic                   upd_alt_taken,
    input  logic [PROV_W-1:0]      upd_provider,
    input  logic [BIDX_W-1:0]      upd_bidx,
    input  logic [NTAB*TIDX_W-1:0] upd_idx,
    input  logic [TAGS_W-1:0]      upd_tag
);
    import tage_pkg::*;

    localparam int HIST_W    = BASE_HIST << (NTAB - 1);
    localparam int TAG_PC_LO = 2 + BIDX_W;
    localparam logic signed [CTR_W-1:0] CTR_MAX    = {1'b0, {(CTR_W-1){1'b1}}};
    localparam logic signed [CTR_W-1:0] CTR_MIN    = {1'b1, {(CTR_W-1){1'b0}}};
    localparam logic signed [CTR_W-1:0] CTR_WEAK_T = '0;
    localparam logic signed [CTR_W-1:0] CTR_WEAK_N = '1;

    typedef struct packed {
        logic [HIST_W-1:0] ghist;
        logic [PATH_W-1:0] path;
    } hstate_t;

    hstate_t st_d, st_q;

    logic [HIST_W-1:0] ghist_q;
    logic [PATH_W-1:0] path_q;
    logic              upd_pbit;
    logic              unused_upd_pc;

    assign ghist_q       = st_q.ghist;
    assign path_q        = st_q.path;
    assign upd_pbit      = upd_pc[PATH_BIT];
    assign unused_upd_pc = ^upd_pc;

    tent_t             rd_ent [NTAB];
    tent_t             up_ent [NTAB];
    tent_t             wr_ent [NTAB];
    logic              wr_en  [NTAB];
    logic [NTAB-1:0]   hit, dir;

    logic [1:0]        bim_rd, bim_up, bim_wr;
    logic              bim_we;

    // lookup side: one hash and one bank per tagged table
    for (genvar g = 0; g < NTAB; g++) begin : g_tab
        logic [TIDX_W-1:0] h_idx;
        logic [TAG_W-1:0]  h_tag;

        tage_hash #(
            .PC_W(PC_W), .HIST_W(HIST_W), .PATH_W(PATH_W),
            .HLEN(BASE_HIST << g), .TIDX_W(TIDX_W), .TAG_PC_LO(TAG_PC_LO)
        ) i_hash (
            .pc(pred_pc), .ghist(ghist_q), .path(path_q),
            .idx(h_idx), .tag(h_tag)
        );

        tage_bank #(.TIDX_W(TIDX_W)) i_bank (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(h_idx), .rd_ent(rd_ent[g]),
            .up_idx(upd_idx[g*TIDX_W +: TIDX_W]), .up_ent(up_ent[g]),
            .wr_en(wr_en[g]), .wr_ent(wr_ent[g])
        );

        assign pred_idx[g*TIDX_W +: TIDX_W] = h_idx;
        assign pred_tag[g*TAG_W +: TAG_W]   = h_tag;
        assign hit[g] = rd_ent[g].vld && (rd_ent[g].tag == h_tag);
        assign dir[g] = ~rd_ent[g].ctr[CTR_W-1];
    end

    assign pred_bidx = pred_pc[2 +: BIDX_W];

    tage_bimodal #(.BIDX_W(BIDX_W)) i_bim (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_bidx), .rd_ctr(bim_rd),
        .up_idx(upd_bidx), .up_ctr(bim_up),
        .wr_en(bim_we), .wr_ctr(bim_wr)
    );

    tage_select #(.NTAB(NTAB), .PROV_W(PROV_W)) i_sel (
        .hit(hit), .dir(dir), .base_dir(bim_rd[1]),
        .provider(pred_provider), .taken(pred_taken),
        .alt_taken(pred_alt_taken)
    );

    // update side
    logic mispred, right, alloc_found;
    logic [PROV_W-1:0] alloc_tab;

    always_comb begin
        st_d    = st_q;
        mispred = upd_valid && (upd_pred_taken != upd_taken);
        right   = (upd_pred_taken == upd_taken);

        alloc_found = 1'b0;
        alloc_tab   = '0;
        for (int t = 0; t < NTAB; t++) begin
            if (!alloc_found && (PROV_W'(t + 1) > upd_provider)
                && (up_ent[t].usef == '0)) begin
                alloc_found = 1'b1;
                alloc_tab   = PROV_W'(t);
            end
        end

        for (int t = 0; t < NTAB; t++) begin
            wr_en[t]  = 1'b0;
            wr_ent[t] = up_ent[t];
            if (upd_valid && (upd_provider == PROV_W'(t + 1))) begin
                wr_en[t] = 1'b1;
                if (upd_taken && (up_ent[t].ctr != CTR_MAX)) begin
                    wr_ent[t].ctr = up_ent[t].ctr + 1'b1;
                end else if (!upd_taken && (up_ent[t].ctr != CTR_MIN)) begin
                    wr_ent[t].ctr = up_ent[t].ctr - 1'b1;
                end
                if (right && (upd_alt_taken != upd_pred_taken)
                    && (up_ent[t].usef != '1)) begin
                    wr_ent[t].usef = up_ent[t].usef + 1'b1;
                end else if (!right && (upd_alt_taken == upd_taken)
                             && (up_ent[t].usef != '0)) begin
                    wr_ent[t].usef = up_ent[t].usef - 1'b1;
                end
            end else if (mispred && (PROV_W'(t + 1) > upd_provider)) begin
                if (alloc_found) begin
                    if (alloc_tab == PROV_W'(t)) begin
                        wr_en[t]       = 1'b1;
                        wr_ent[t].vld  = 1'b1;
                        wr_ent[t].tag  = upd_tag[t*TAG_W +: TAG_W];
                        wr_ent[t].ctr  = upd_taken ? CTR_WEAK_T : CTR_WEAK_N;
                        wr_ent[t].usef = '0;
                    end
                end else if (up_ent[t].usef != '0) begin
                    wr_en[t]       = 1'b1;
                    wr_ent[t].usef = up_ent[t].usef - 1'b1;
                end
            end
        end

        bim_we = upd_valid && (upd_provider == '0);
        bim_wr = bim_up;
        if (upd_taken && (bim_up != 2'b11)) begin
            bim_wr = bim_up + 2'b01;
        end else if (!upd_taken && (bim_up != 2'b00)) begin
            bim_wr = bim_up - 2'b01;
        end

        if (upd_valid) begin
            st_d.ghist = {ghist_q[HIST_W-2:0], upd_taken};
            st_d.path  = {path_q[PATH_W-2:0], upd_pbit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tage_predictor_chk.sv
module tage_predictor_chk #(
    parameter int NTAB   = 4,
    parameter int PROV_W = 3,
    parameter int HIST_W = 32,
    parameter int PATH_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic              upd_pbit,
    input logic [HIST_W-1:0] ghist_q,
    input logic [PATH_W-1:0] path_q,
    input logic [PROV_W-1:0] pred_provider,
    input logic              pred_taken,
    input logic              pred_alt_taken
);
    a_r5_provider_range: assert property (@(posedge clk) disable iff (!rst_n)
        pred_provider <= PROV_W'(NTAB));

    a_r6_alt_on_base: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_provider == '0) |-> (pred_alt_taken == pred_taken));

    a_r11_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist_q == {$past(ghist_q[HIST_W-2:0]), $past(upd_taken)}));

    a_r11_path_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (path_q == {$past(path_q[PATH_W-2:0]), $past(upd_pbit)}));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(ghist_q) && $stable(path_q)));

endmodule

bind tage_predictor tage_predictor_chk #(
    .NTAB(NTAB), .PROV_W(PROV_W), .HIST_W(HIST_W), .PATH_W(PATH_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_pbit(upd_pbit), .ghist_q(ghist_q), .path_q(path_q),
    .pred_provider(pred_provider), .pred_taken(pred_taken),
    .pred_alt_taken(pred_alt_taken)
);

// File: tb/test_tage_predictor.sv
`timescale 1ns/1ps
module test_tage_predictor;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_alt_taken;
    logic [2:0]  pred_provider;
    logic [7:0]  pred_bidx;
    logic [23:0] pred_idx;
    logic [31:0] pred_tag;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0, upd_pred_taken = 1'b0, upd_alt_taken = 1'b0;
    logic [2:0]  upd_provider = '0;
    logic [7:0]  upd_bidx = '0;
    logic [23:0] upd_idx = '0;
    logic [31:0] upd_tag = '0;

    always #2.5 clk = ~clk;

    tage_predictor i_tage_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_alt_taken(pred_alt_taken), .pred_provider(pred_provider),
        .pred_bidx(pred_bidx), .pred_idx(pred_idx), .pred_tag(pred_tag),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred_taken(upd_pred_taken), .upd_alt_taken(upd_alt_taken),
        .upd_provider(upd_provider), .upd_bidx(upd_bidx), .upd_idx(upd_idx),
        .upd_tag(upd_tag)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    // reference state
    bit          m_vld [NT][64];
    logic [7:0]  m_tag [NT][64];
    int          m_ctr [NT][64];
    int          m_u   [NT][64];
    int          m_bim [256];
    logic [31:0] m_gh;
    logic [15:0] m_ph;

    bit          e_taken, e_alt;
    int          e_prov;
    logic [7:0]  e_bidx;
    logic [5:0]  e_idx [NT];
    logic [7:0]  e_tag [NT];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fold(input logic [31:0] x, input int n, input int w);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r[i % w] ^= x[i];
        return r;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 64; i++) begin
                m_vld[t][i] = 0; m_tag[t][i] = '0; m_ctr[t][i] = 0; m_u[t][i] = 0;
            end
        for (int i = 0; i < 256; i++) m_bim[i] = 1;
        m_gh = '0; m_ph = '0;
    endtask

    task automatic model_predict(input logic [31:0] pc);
        bit b;
        e_bidx = pc[9:2];
        b = (m_bim[e_bidx] >= 2);
        e_taken = b; e_alt = b; e_prov = 0;
        for (int t = 0; t < NT; t++) begin
            int len  = 4 << t;
            int plen = (len < 16) ? len : 16;
            e_idx[t] = pc[7:2] ^ pc[13:8] ^ 6'(fold(m_gh, len, 6)) ^ 6'(fold({16'h0, m_ph}, plen, 6));
            e_tag[t] = pc[17:10] ^ fold(m_gh, len, 8) ^ 8'(fold(m_gh, len, 7) << 1);
            if (m_vld[t][e_idx[t]] && m_tag[t][e_idx[t]] == e_tag[t]) begin
                e_alt = e_taken;
                e_taken = (m_ctr[t][e_idx[t]] >= 0);
                e_prov = t + 1;
            end
        end
    endtask

    task automatic model_update(input logic [31:0] pc, input bit tk);
        bit mis = (e_taken != tk);
        if (e_prov == 0) begin
            if (tk && m_bim[e_bidx] < 3) m_bim[e_bidx]++;
            else if (!tk && m_bim[e_bidx] > 0) m_bim[e_bidx]--;
        end else begin
            int p = e_prov - 1;
            int i = e_idx[p];
            if (tk && m_ctr[p][i] < 3) m_ctr[p][i]++;
            else if (!tk && m_ctr[p][i] > -4) m_ctr[p][i]--;
            if (!mis && e_alt != e_taken && m_u[p][i] < 3) m_u[p][i]++;
            else if (mis && e_alt == tk && m_u[p][i] > 0) m_u[p][i]--;
        end
        if (mis) begin
            int found = -1;
            for (int t = e_prov; t < NT; t++)
                if (found < 0 && m_u[t][e_idx[t]] == 0) found = t;
            if (found >= 0) begin
                m_vld[found][e_idx[found]] = 1;
                m_tag[found][e_idx[found]] = e_tag[found];
                m_ctr[found][e_idx[found]] = tk ? 0 : -1;
                m_u[found][e_idx[found]]   = 0;
            end else begin
                for (int t = e_prov; t < NT; t++)
                    if (m_u[t][e_idx[t]] > 0) m_u[t][e_idx[t]]--;
            end
        end
        m_gh = {m_gh[30:0], tk};
        m_ph = {m_ph[14:0], pc[2]};
    endtask

    task automatic check_pred();
        check(pred_provider == 3'(e_prov), "R5 R9 R10", "provider", pred_provider, e_prov);
        check(pred_taken == e_taken, "R5 R7 R8", "direction", pred_taken, e_taken);
        check(pred_alt_taken == e_alt, "R6", "alternate", pred_alt_taken, e_alt);
        check(pred_bidx == e_bidx, "R2", "fallback index", pred_bidx, e_bidx);
        for (int t = 0; t < NT; t++) begin
            check(pred_idx[t*6 +: 6] == e_idx[t], "R3 R11", "table index", pred_idx[t*6 +: 6], e_idx[t]);
            check(pred_tag[t*8 +: 8] == e_tag[t], "R4 R11", "table tag", pred_tag[t*8 +: 8], e_tag[t]);
        end
    endtask

    // one branch: lookup, compare, update in the same cycle (R12)
    task automatic step(input logic [31:0] pc, input bit tk);
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc;
        #1;
        model_predict(pc);
        check_pred();
        upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
        upd_pred_taken = e_taken; upd_alt_taken = e_alt;
        upd_provider = 3'(e_prov); upd_bidx = e_bidx;
        for (int t = 0; t < NT; t++) begin
            upd_idx[t*6 +: 6] = e_idx[t];
            upd_tag[t*8 +: 8] = e_tag[t];
        end
        #1;
        // R12: the same-cycle lookup still reflects the pre-update state
        check(pred_taken == e_taken, "R12", "same-cycle lookup", pred_taken, e_taken);
        @(posedge clk);
        model_update(pc, tk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            upd_valid = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] pool [16];
        int          bias [16];
        int          hits;
        void'($urandom(32'h1234_5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        pred_pc = 32'h0000_4A10;
        #1;
        check(pred_taken == 1'b0, "R1", "reset direction", pred_taken, 0);
        check(pred_provider == 3'd0, "R1", "reset provider", pred_provider, 0);
        model_predict(pred_pc);
        check_pred();

        // R9: first taken branch mispredicts from the fallback and allocates
        step(32'h0000_4A10, 1'b1);
        step(32'h0000_4A10, 1'b1);

        // R5 R9: alternating branch must end up served by tagged tables
        hits = 0;
        for (int k = 0; k < 200; k++) begin
            step(32'h0000_1F40, k[0]);
            if (k >= 150 && pred_provider != 3'd0) hits++;
        end
        check(hits >= 25, "R5 R9", "tagged hits on alternating branch", hits, 25);

        // R11: idle cycles leave lookups unchanged
        idle(4);
        step(32'h0000_1F40, 1'b0);

        // random traffic over a small address pool, with idle gaps
        for (int i = 0; i < 16; i++) begin
            pool[i] = $urandom & 32'h0003_FFFC;
            bias[i] = $urandom_range(100);
        end
        for (int k = 0; k < 3000; k++) begin
            int s = $urandom_range(15);
            if ($urandom_range(9) == 0) idle($urandom_range(1, 3));
            step(pool[s], ($urandom_range(99) < bias[s]));
        end

        @(negedge clk);
        upd_valid = 1'b0;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule